// File: doc/BRIEF.md
# MII Receive Error Substitution Unit

This block sits on the 100 Mb/s receive path, after the symbol decoder and in front of the MII receive outputs. Each clock it takes one decoded nibble with a valid flag. With the nibble come flags for a code violation, an IDLE symbol, a start-of-stream delimiter, an end-of-stream delimiter (the T/R pair) and loss of link. The block tracks whether a stream is open. It detects a premature end, which is two back-to-back IDLE symbols inside a stream. It also times each stream against a receive timeout.

Every cycle, the block either passes the nibble through unchanged with the receive error output low, or puts a fixed code for the most urgent error class in its place and raises the receive error output. Four configuration inputs choose the code for code violations, choose the code for premature ends, and decide whether link errors and timeouts are reported at all. Nibble, valid and error all leave through one register stage, so the three stay aligned.

Top module: `mii_rxerr_subst`

## Requirements
- R1: While reset is asserted and directly after it, `mii_rxd` is 0h and `mii_rx_dv` and `mii_rx_er` are 0. Reset closes any open stream and clears the IDLE tracker and the timeout counter, so IDLE symbols seen before the next start-of-stream raise no error.
- R2: With no error active, `mii_rxd` equals `dec_nib`, `mii_rx_dv` equals `dec_valid` and `mii_rx_er` is 0, all one clock after the input.
- R3: A cycle with `dec_code_err`=1 gives `mii_rx_er`=1 one clock later. `mii_rxd` is 5h when `cfg_code_alt`=1 and 6h when it is 0.
- R4: Inside an open stream, an IDLE symbol that directly follows another IDLE symbol is a premature end. It gives `mii_rx_er`=1 with `mii_rxd` 4h when `cfg_pe_alt`=1 and 6h when it is 0. A non-IDLE symbol between two IDLEs cancels the pair.
- R5: After a premature end, the error substitution continues through the cycle that carries `dec_eos`. It stops after that cycle and re-arms at the next `dec_sos`.
- R6: When `dec_link_lost`=1 and `cfg_link_rpt`=1, the output is 3h with `mii_rx_er`=1. When `cfg_link_rpt`=0, the nibble passes through unchanged with `mii_rx_er`=0.
- R7: A stream still open on its TIMEOUT_CYC-th cycle after the `dec_sos` cycle is timed out. From then until its `dec_eos` cycle, the output is 2h with `mii_rx_er`=1. The default TIMEOUT_CYC is 18050, which is 722 us at 25 MHz.
- R8: When `cfg_pkt_rpt`=0, a timed-out stream passes its nibbles through unchanged with `mii_rx_er`=0.
- R9: When several errors are active in the same cycle, one code is chosen. Priority from highest to lowest is link error, code error, premature end, timeout.
- R10: The timeout count restarts at every `dec_sos`, including one that arrives while a stream is open. The count stops at `dec_eos`, so no timeout is reported between streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_nib | input | 4 | Decoded receive nibble |
| dec_valid | input | 1 | Nibble belongs to frame data |
| dec_code_err | input | 1 | Code violation on this symbol |
| dec_idle | input | 1 | This symbol is IDLE |
| dec_sos | input | 1 | Start-of-stream delimiter detected |
| dec_eos | input | 1 | End-of-stream delimiter pair detected |
| dec_link_lost | input | 1 | Link loss indicated |
| cfg_code_alt | input | 1 | Code violation code: 1 selects 5h, 0 selects 6h |
| cfg_pe_alt | input | 1 | Premature end code: 1 selects 4h, 0 selects 6h |
| cfg_link_rpt | input | 1 | Report link errors as 3h |
| cfg_pkt_rpt | input | 1 | Report timeouts as 2h |
| mii_rxd | output | 4 | Receive nibble to MII |
| mii_rx_dv | output | 1 | Receive data valid to MII |
| mii_rx_er | output | 1 | Receive error to MII |

## Verification
Every result appears exactly one rising edge after the inputs that cause it. The bench therefore drives on a falling edge and samples at the next falling edge, before it drives again, and each check belongs to the inputs of the cycle just before it. State-driven results are counted in cycles from the cycle that triggered them. The premature end is due on the second IDLE. The timeout is due on the TIMEOUT_CYC-th cycle after the start-of-stream cycle, with TIMEOUT_CYC set to 20 in the bench. The bench checks that the cycle before each of these is still clean, and that the substitution ends directly after the end-of-stream cycle.

// File: rtl/mii_rxerr_pkg.sv
package mii_rxerr_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] NIB_LINK     = 4'h3;
  localparam logic [NIB_W-1:0] NIB_TOUT     = 4'h2;
  localparam logic [NIB_W-1:0] NIB_PREM_ALT = 4'h4;
  localparam logic [NIB_W-1:0] NIB_CODE_ALT = 4'h5;
  localparam logic [NIB_W-1:0] NIB_SHARED   = 4'h6;

  typedef enum logic [2:0] {
    ERR_NONE,
    ERR_LINK,
    ERR_CODE,
    ERR_PREM,
    ERR_TOUT
  } err_cls_e;

  // Fixed priority: link, code, premature end, timeout.
  function automatic err_cls_e pick_class(input logic link_hit,
                                          input logic code_hit,
                                          input logic prem_hit,
                                          input logic tout_hit);
    err_cls_e c;
    if (link_hit)      c = ERR_LINK;
    else if (code_hit) c = ERR_CODE;
    else if (prem_hit) c = ERR_PREM;
    else if (tout_hit) c = ERR_TOUT;
    else               c = ERR_NONE;
    return c;
  endfunction

  function automatic logic [NIB_W-1:0] class_nibble(input err_cls_e c,
                                                    input logic code_alt,
                                                    input logic prem_alt,
                                                    input logic [NIB_W-1:0] raw);
    logic [NIB_W-1:0] n;
    case (c)
      ERR_LINK: n = NIB_LINK;
      ERR_CODE: n = code_alt ? NIB_CODE_ALT : NIB_SHARED;
      ERR_PREM: n = prem_alt ? NIB_PREM_ALT : NIB_SHARED;
      ERR_TOUT: n = NIB_TOUT;
      default:  n = raw;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mii_rxerr_rstsync.sv
module mii_rxerr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) shift_q <= '0;
    else          shift_q <= shift_d;
  end

  assign rst_n_s = shift_q[STAGES-1];

endmodule

// File: rtl/mii_rxerr_stream.sv
module mii_rxerr_stream (
  input  logic clk,
  input  logic rst_n,
  input  logic sos,
  input  logic eos,
  input  logic idle,
  output logic act,
  output logic prem
);

  logic act_q, act_d;
  logic idle_q, idle_d;
  logic pe_q, pe_d;
  logic prem_now;

  always_comb begin
    prem_now = act_q & idle & idle_q;

    act_d = act_q;
    if (eos) act_d = 1'b0;
    if (sos) act_d = 1'b1;

    if (sos) idle_d = 1'b0;
    else     idle_d = act_q & idle & ~eos;

    if (sos | eos) pe_d = 1'b0;
    else           pe_d = pe_q | prem_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idle_q <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      idle_q <= idle_d;
      pe_q   <= pe_d;
    end
  end

  assign act  = act_q;
  assign prem = prem_now | pe_q;

  AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prem && !sos && !eos) |=> prem); // R5
  AST_PE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !sos) |=> (!act && !pe_q)); // R5
  AST_PE_NEEDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !sos) |=> !prem); // R4

endmodule

// File: rtl/mii_rxerr_timer.sv
module mii_rxerr_timer #(
  parameter int LIMIT = 18050,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sos,
  input  logic act,
  output logic tout
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;
  logic             cnt_en;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_en  = sos | (act & ~at_last);
    if (sos)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tout = act & at_last;

  AST_TMR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !sos) |=> $stable(cnt_q)); // R10
  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sos |=> (cnt_q == '0)); // R10
  AST_TMR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7

endmodule

// File: rtl/mii_rxerr_outmux.sv
module mii_rxerr_outmux
  import mii_rxerr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib,
  input  logic             vld,
  input  logic             code_err,
  input  logic             link_lost,
  input  logic             prem,
  input  logic             tout,
  input  logic             code_alt,
  input  logic             prem_alt,
  input  logic             link_rpt,
  input  logic             pkt_rpt,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er
);

  err_cls_e         cls;
  logic             link_hit;
  logic             tout_hit;
  logic [NIB_W-1:0] rxd_d, rxd_q;
  logic             er_d, er_q;
  logic             dv_d, dv_q;

  always_comb begin
    link_hit = link_lost & link_rpt;
    tout_hit = tout & pkt_rpt;
    cls      = pick_class(link_hit, code_err, prem, tout_hit);
    rxd_d    = class_nibble(cls, code_alt, prem_alt, nib);
    er_d     = (cls != ERR_NONE);
    dv_d     = vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0;
      er_q  <= 1'b0;
      dv_q  <= 1'b0;
    end else begin
      rxd_q <= rxd_d;
      er_q  <= er_d;
      dv_q  <= dv_d;
    end
  end

  assign rxd   = rxd_q;
  assign rx_er = er_q;
  assign rx_dv = dv_q;

  AST_LINK_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (link_lost && link_rpt) |=> (rx_er && rxd == 4'h3)); // R6
  AST_CODE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err && !(link_lost && link_rpt)) |=>
      (rx_er && rxd == ($past(code_alt) ? 4'h5 : 4'h6))); // R3
  AST_TOUT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (tout && pkt_rpt && !prem && !code_err && !(link_lost && link_rpt)) |=>
      (rx_er && rxd == 4'h2)); // R7
  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(link_lost && link_rpt) && !code_err && !prem && !(tout && pkt_rpt)) |=>
      (!rx_er && rxd == $past(nib))); // R2
  AST_DV_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_dv == $past(vld))); // R2

endmodule

// File: rtl/mii_rxerr_subst.sv
module mii_rxerr_subst
  import mii_rxerr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 18050,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dec_nib,
  input  logic       dec_valid,
  input  logic       dec_code_err,
  input  logic       dec_idle,
  input  logic       dec_sos,
  input  logic       dec_eos,
  input  logic       dec_link_lost,
  input  logic       cfg_code_alt,
  input  logic       cfg_pe_alt,
  input  logic       cfg_link_rpt,
  input  logic       cfg_pkt_rpt,
  output logic [3:0] mii_rxd,
  output logic       mii_rx_dv,
  output logic       mii_rx_er
);

  logic rst_n_s;
  logic strm_act;
  logic prem;
  logic tout;

  mii_rxerr_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  mii_rxerr_stream u_strm (
    .clk   (clk),
    .rst_n (rst_n_s),
    .sos   (dec_sos),
    .eos   (dec_eos),
    .idle  (dec_idle),
    .act   (strm_act),
    .prem  (prem)
  );

  mii_rxerr_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .sos   (dec_sos),
    .act   (strm_act),
    .tout  (tout)
  );

  mii_rxerr_outmux u_mux (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .nib       (dec_nib),
    .vld       (dec_valid),
    .code_err  (dec_code_err),
    .link_lost (dec_link_lost),
    .prem      (prem),
    .tout      (tout),
    .code_alt  (cfg_code_alt),
    .prem_alt  (cfg_pe_alt),
    .link_rpt  (cfg_link_rpt),
    .pkt_rpt   (cfg_pkt_rpt),
    .rxd       (mii_rxd),
    .rx_dv     (mii_rx_dv),
    .rx_er     (mii_rx_er)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!mii_rx_er && !mii_rx_dv)); // R1

endmodule

// File: tb/tb_mii_rxerr_subst.sv
`timescale 1ns/1ps
module tb_mii_rxerr_subst;

  localparam int TO = 20;

  logic       clk;
  logic       rst_n;
  logic [3:0] dec_nib;
  logic       dec_valid, dec_code_err, dec_idle, dec_sos, dec_eos, dec_link_lost;
  logic       cfg_code_alt, cfg_pe_alt, cfg_link_rpt, cfg_pkt_rpt;
  logic [3:0] mii_rxd;
  logic       mii_rx_dv, mii_rx_er;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  mii_rxerr_subst #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .dec_nib(dec_nib), .dec_valid(dec_valid),
    .dec_code_err(dec_code_err), .dec_idle(dec_idle), .dec_sos(dec_sos),
    .dec_eos(dec_eos), .dec_link_lost(dec_link_lost),
    .cfg_code_alt(cfg_code_alt), .cfg_pe_alt(cfg_pe_alt),
    .cfg_link_rpt(cfg_link_rpt), .cfg_pkt_rpt(cfg_pkt_rpt),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0] nib;
    logic       vld;
    logic       code;
    logic       link;
    logic       csel;
    logic       len;
    logic [3:0] exp_d;
    logic       exp_er;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{4'h5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h5, 1'b0, 4'd2},
    '{4'hC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hC, 1'b0, 4'd2},
    '{4'h1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'h5, 1'b1, 4'd3},
    '{4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h6, 1'b1, 4'd3},
    '{4'h9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h3, 1'b1, 4'd6},
    '{4'h9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9, 1'b0, 4'd6},
    '{4'hA, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h3, 1'b1, 4'd9},
    '{4'hA, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h5, 1'b1, 4'd9},
    '{4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 4'd2}
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd6:    return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] ed, input logic ee,
                     input logic edv);
    n_chk++;
    if (mii_rxd !== ed || mii_rx_er !== ee || mii_rx_dv !== edv) begin
      n_fail++;
      $display("FAIL %s: rxd=%h er=%b dv=%b expected rxd=%h er=%b dv=%b",
               req, mii_rxd, mii_rx_er, mii_rx_dv, ed, ee, edv);
    end
  endtask

  // Drive one cycle of inputs, then wait for the falling edge after the
  // capturing rising edge.
  task automatic put(input logic [3:0] nib, input logic vld, input logic code,
                     input logic idle, input logic sos, input logic eos,
                     input logic link);
    dec_nib = nib; dec_valid = vld; dec_code_err = code; dec_idle = idle;
    dec_sos = sos; dec_eos = eos; dec_link_lost = link;
    @(negedge clk);
  endtask

  task automatic plain(input logic [3:0] nib);
    put(nib, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle1();
    put(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_code_alt = 1'b1; cfg_pe_alt = 1'b1; cfg_link_rpt = 1'b1; cfg_pkt_rpt = 1'b1;
    dec_nib = 4'hF; dec_valid = 1'b1; dec_code_err = 1'b1; dec_idle = 1'b0;
    dec_sos = 1'b0; dec_eos = 1'b0; dec_link_lost = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'h0, 1'b0, 1'b0);
    put(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 4'h0, 1'b0, 1'b0);

    // Table walk: no stream open.
    for (int i = 0; i < 9; i++) begin
      cfg_code_alt = TBL[i].csel;
      cfg_link_rpt = TBL[i].len;
      put(TBL[i].nib, TBL[i].vld, TBL[i].code, 1'b0, 1'b0, 1'b0, TBL[i].link);
      chk(req_name(TBL[i].req), TBL[i].exp_d, TBL[i].exp_er, TBL[i].vld);
    end
    cfg_code_alt = 1'b1; cfg_link_rpt = 1'b1;

    // R4 / R5: premature end with alternate code.
    cfg_pe_alt = 1'b1;
    put(4'h5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 sos cycle", 4'h5, 1'b0, 1'b0);
    plain(4'hA); chk("R2 in stream", 4'hA, 1'b0, 1'b1);
    idle1();     chk("R4 first idle", 4'h0, 1'b0, 1'b0);
    idle1();     chk("R4 second idle", 4'h4, 1'b1, 1'b0);
    plain(4'h7); chk("R5 sticky", 4'h4, 1'b1, 1'b1);
    put(4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 eos cycle", 4'h4, 1'b1, 1'b1);
    plain(4'h9); chk("R5 after eos", 4'h9, 1'b0, 1'b1);
    idle1();     idle1(); chk("R5 idles outside stream", 4'h0, 1'b0, 1'b0);

    // R4: interrupted idle pair, then shared code 6h.
    cfg_pe_alt = 1'b0;
    put(4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 rearm", 4'h1, 1'b0, 1'b0);
    idle1();
    plain(4'h2); chk("R4 broken pair", 4'h2, 1'b0, 1'b1);
    idle1();     chk("R4 lone idle", 4'h0, 1'b0, 1'b0);
    idle1();     chk("R4 shared code", 4'h6, 1'b1, 1'b0);
    put(4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    plain(4'h3); chk("R5 cleared", 4'h3, 1'b0, 1'b1);

    // R7 / R8: timeout.
    put(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int c = 1; c < TO; c++) begin
      plain(4'hB);
      if (c == TO - 1) chk("R7 before limit", 4'hB, 1'b0, 1'b1);
    end
    plain(4'hB); chk("R7 at limit", 4'h2, 1'b1, 1'b1);
    cfg_pkt_rpt = 1'b0;
    plain(4'hD); chk("R8 masked", 4'hD, 1'b0, 1'b1);
    cfg_pkt_rpt = 1'b1;
    plain(4'hD); chk("R7 still timed out", 4'h2, 1'b1, 1'b1);
    put(4'hD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 eos cycle", 4'h2, 1'b1, 1'b1);
    begin
      int bad = 0;
      for (int c = 0; c < 2 * TO; c++) begin
        plain(4'hE);
        if (mii_rx_er !== 1'b0) bad++;
      end
      n_chk++;
      if (bad != 0) begin
        n_fail++;
        $display("FAIL R10 stopped: errors=%0d expected 0", bad);
      end
    end

    // R10: restart on a second sos inside an open stream.
    put(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int c = 0; c < TO - 5; c++) plain(4'h4);
    put(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 second sos", 4'h0, 1'b0, 1'b0);
    for (int c = 1; c < TO; c++) plain(4'h4);
    chk("R10 restarted count", 4'h4, 1'b0, 1'b1);
    plain(4'h4); chk("R10 limit after restart", 4'h2, 1'b1, 1'b1);

    // R9: priority inside a timed-out stream.
    cfg_pe_alt = 1'b1;
    idle1();     chk("R9 tout only", 4'h2, 1'b1, 1'b0);
    idle1();     chk("R9 prem over tout", 4'h4, 1'b1, 1'b0);
    put(4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 code over prem", 4'h5, 1'b1, 1'b1);
    put(4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 link over all", 4'h3, 1'b1, 1'b1);

    // R1: reset mid-stream with sticky errors, then idles without sos.
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-stream reset", 4'h0, 1'b0, 1'b0);
    put(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle1();
    idle1();     chk("R1 tracker cleared", 4'h0, 1'b0, 1'b0);
    plain(4'h6); chk("R1 stream closed", 4'h6, 1'b0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule